// File: doc/BRIEF.md
# Dual-Direction Processor Mailbox

This block passes short messages between an external host processor and an on-chip processor. Each direction has its own 256-byte message buffer, a one-bit "message ready" flag, a buffer index and an interrupt mask. The inbound direction runs from the host to the on-chip processor. The outbound direction runs from the on-chip processor to the host. The side that writes a direction's messages owns its flag. The owner sets the flag to announce a message. The reader clears the flag to acknowledge it.

The on-chip processor uses an APB slave port. This port has a 10-bit word address, 8-bit write data and 16-bit read data. The on-chip processor reaches every buffer byte and every control register directly. The host uses an 8-bit strobed port with a 3-bit register select. The host reaches buffer bytes only through the two index registers, which step forward after every data access. One level-sensitive interrupt goes to each processor. Both ports are sampled on one clock.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, both flags, both indexes, both masks, both interrupts and `host_data_oe_o` are 0, and `host_data_o` reads 0.
- R2: A host write to register 0 sets the inbound flag when the data is 0x01 and clears it when the data is 0x00. Other values leave the flag unchanged. An APB write of any value to 0x200 clears the flag. Both sides read the flag in bit 0: the host at register 0 and the APB at 0x200.
- R3: An APB write to 0x201 sets the outbound flag when the data is 0x01 and clears it when the data is 0x00. Other values leave the flag unchanged. A host write of any value to register 1 clears the flag. Both sides read the flag in bit 0: the host at register 1 and the APB at 0x201.
- R4: A host write of any value to register 2 clears the inbound index, and a write to register 3 clears the outbound index. An APB write of 0x00 to 0x204 clears the inbound index, and to 0x205 clears the outbound index. Nonzero APB writes to these two addresses are ignored. The indexes read back at host registers 2 and 3 and at APB 0x204 and 0x205.
- R5: A host read or write of register 4 accesses inbound buffer byte [inbound index]. A host read or write of register 5 accesses outbound buffer byte [outbound index]. Each such access advances that index by one afterwards. The index wraps from 255 to 0, and the access never touches the other buffer.
- R6: APB addresses 0x000–0x0FF map directly to the inbound buffer and 0x100–0x1FF to the outbound buffer. All APB reads return the byte zero-extended to 16 bits. Unmapped APB addresses read 0.
- R7: An APB write takes effect only in a cycle where psel, penable and pwrite are all high.
- R8: The inbound mask is written and read at APB 0x202 and read by the host at register 7. `cpu_irq_o` is high exactly while the inbound flag is 1 and mask bit 0 is 1.
- R9: The outbound mask is written and read by the host at register 6 and read at APB 0x203. `host_irq_o` is high exactly while the outbound flag is 1 and mask bit 0 is 1.
- R10: `host_data_oe_o` is high only while `host_cs_ni` is low, `host_rw_ni` is high and `host_oe_ni` is low. In every other case `host_data_o` is 0.
- R11: A host access commits once, on the first clock at which `host_as_ni` is seen high after being low while `host_cs_ni` is low. Holding the strobe low longer does not repeat the access, and a strobe edge with chip select high does nothing.
- R12: When both sides commit in the same cycle, the non-owner's clear of a flag wins over the owner's set. An APB index reset wins over a host increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 10 | APB word address |
| pwdata_i | input | 8 | APB write data |
| prdata_o | output | 16 | APB read data, zero-extended byte |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_as_ni | input | 1 | Host address strobe, active low; its rising edge commits the access |
| host_rw_ni | input | 1 | Host direction: 1 read, 0 write |
| host_oe_ni | input | 1 | Host output enable, active low |
| host_addr_i | input | 3 | Host register select |
| host_data_i | input | 8 | Host write data |
| host_data_o | output | 8 | Host read data |
| host_data_oe_o | output | 1 | High while the block drives host_data_o |
| cpu_irq_o | output | 1 | Inbound message interrupt to the on-chip processor |
| host_irq_o | output | 1 | Outbound message interrupt to the host |

## Verification
A wrong flag or mask appears on the interrupt pins in the cycle after the offending commit, because each interrupt is a plain AND of two registers. A stray index step is invisible until the next data access through the host port. It then returns a byte from the wrong slot, so the model keeps exact images of both buffers and compares every host data read. Indexes are also read back through registers after random traffic. This catches a missed wrap or a cross-buffer write within a few operations. Same-cycle collisions are driven on purpose, because only those show whether the clear or the set takes priority.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SET_CODE = 8'h01;
  localparam logic [BYTE_W-1:0] CLR_CODE = 8'h00;

  typedef enum logic [2:0] {
    H_IN_FLAG  = 3'd0,
    H_OUT_FLAG = 3'd1,
    H_IN_IDX   = 3'd2,
    H_OUT_IDX  = 3'd3,
    H_IN_DATA  = 3'd4,
    H_OUT_DATA = 3'd5,
    H_OUT_MASK = 3'd6,
    H_IN_MASK  = 3'd7
  } host_reg_e;

  typedef enum logic [2:0] {
    C_IN_FLAG  = 3'd0,
    C_OUT_FLAG = 3'd1,
    C_IN_MASK  = 3'd2,
    C_OUT_MASK = 3'd3,
    C_IN_IDX   = 3'd4,
    C_OUT_IDX  = 3'd5
  } cpu_reg_e;
endpackage

// File: rtl/mbox_flag.sv
module mbox_flag
  import mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_we_i,
  input  logic [BYTE_W-1:0] own_data_i,
  input  logic              peer_we_i,
  output logic              flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 flag_o <= 1'b0;
    else if (peer_we_i)                          flag_o <= 1'b0;  // peer clear wins
    else if (own_we_i && own_data_i == SET_CODE) flag_o <= 1'b1;
    else if (own_we_i && own_data_i == CLR_CODE) flag_o <= 1'b0;
  end

  // R12 (also R2, R3)
  peer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_we_i |=> !flag_o);

  // R2 (also R3)
  own_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_we_i && !peer_we_i && own_data_i == SET_CODE |=> flag_o);

  // R3 (also R2)
  odd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_we_i && !peer_we_i && own_data_i != SET_CODE && own_data_i != CLR_CODE
    |=> $stable(flag_o));
endmodule

// File: rtl/mbox_index.sv
module mbox_index #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (clr_i)   idx_o <= '0;
    else if (inc_i)   idx_o <= idx_o + 1'b1;  // natural wrap
  end

  // R5
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> idx_o == IDX_W'($past(idx_o) + 1'b1));

  // R4 (also R12)
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> idx_o == '0);
endmodule

// File: rtl/mbox_buffer.sv
module mbox_buffer #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              h_we_i,
  input  logic [IDX_W-1:0]  h_addr_i,
  input  logic [BYTE_W-1:0] h_wdata_i,
  output logic [BYTE_W-1:0] h_rdata_o,
  input  logic              c_we_i,
  input  logic [IDX_W-1:0]  c_addr_i,
  input  logic [BYTE_W-1:0] c_wdata_i,
  output logic [BYTE_W-1:0] c_rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  // host port written last: wins on a same-address collision
  always_ff @(posedge clk_i) begin
    if (c_we_i) mem_q[c_addr_i] <= c_wdata_i;
    if (h_we_i) mem_q[h_addr_i] <= h_wdata_i;
  end

  assign h_rdata_o = mem_q[h_addr_i];
  assign c_rdata_o = mem_q[c_addr_i];
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned PADDR_W  = 10,
  parameter int unsigned PRDATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [PADDR_W-1:0]  paddr_i,
  input  logic [BYTE_W-1:0]   pwdata_i,
  output logic [PRDATA_W-1:0] prdata_o,
  input  logic                host_cs_ni,
  input  logic                host_as_ni,
  input  logic                host_rw_ni,
  input  logic                host_oe_ni,
  input  logic [2:0]          host_addr_i,
  input  logic [BYTE_W-1:0]   host_data_i,
  output logic [BYTE_W-1:0]   host_data_o,
  output logic                host_data_oe_o,
  output logic                cpu_irq_o,
  output logic                host_irq_o
);
  localparam int unsigned BUF_SPAN = IDX_W + 1;
  localparam int unsigned REG_BLK  = (1 << BUF_SPAN) >> 3;

  // ---------------- APB decode ----------------
  logic apb_wr, buf_zone, in_buf_hit, out_buf_hit, reg_hit;
  logic [2:0] reg_off;

  assign apb_wr      = psel_i & penable_i & pwrite_i;
  assign buf_zone    = (paddr_i >> BUF_SPAN) == '0;
  assign in_buf_hit  = buf_zone & ~paddr_i[IDX_W];
  assign out_buf_hit = buf_zone &  paddr_i[IDX_W];
  assign reg_hit     = (paddr_i >> 3) == PADDR_W'(REG_BLK);
  assign reg_off     = paddr_i[2:0];

  logic c_wr_in_flag, c_wr_out_flag, c_wr_in_mask, c_wr_in_idx, c_wr_out_idx;
  assign c_wr_in_flag  = apb_wr & reg_hit & (reg_off == C_IN_FLAG);
  assign c_wr_out_flag = apb_wr & reg_hit & (reg_off == C_OUT_FLAG);
  assign c_wr_in_mask  = apb_wr & reg_hit & (reg_off == C_IN_MASK);
  assign c_wr_in_idx   = apb_wr & reg_hit & (reg_off == C_IN_IDX)  & (pwdata_i == CLR_CODE);
  assign c_wr_out_idx  = apb_wr & reg_hit & (reg_off == C_OUT_IDX) & (pwdata_i == CLR_CODE);

  // ---------------- host strobe ----------------
  logic as_q, host_evt, host_wr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) as_q <= 1'b1;
    else         as_q <= host_as_ni;
  end
  // commit on strobe release while selected
  assign host_evt = ~host_cs_ni & host_as_ni & ~as_q;
  assign host_wr  = host_evt & ~host_rw_ni;

  logic h_in_data, h_out_data;
  assign h_in_data  = host_evt & (host_addr_i == H_IN_DATA);
  assign h_out_data = host_evt & (host_addr_i == H_OUT_DATA);

  // ---------------- state ----------------
  logic in_flag, out_flag;
  logic [IDX_W-1:0] in_idx, out_idx;
  logic [BYTE_W-1:0] in_mask_q, out_mask_q;

  mbox_flag u_in_flag (
    .clk_i, .rst_ni,
    .own_we_i   (host_wr & (host_addr_i == H_IN_FLAG)),
    .own_data_i (host_data_i),
    .peer_we_i  (c_wr_in_flag),
    .flag_o     (in_flag)
  );

  mbox_flag u_out_flag (
    .clk_i, .rst_ni,
    .own_we_i   (c_wr_out_flag),
    .own_data_i (pwdata_i),
    .peer_we_i  (host_wr & (host_addr_i == H_OUT_FLAG)),
    .flag_o     (out_flag)
  );

  mbox_index #(.IDX_W(IDX_W)) u_in_idx (
    .clk_i, .rst_ni,
    .clr_i (c_wr_in_idx | (host_wr & (host_addr_i == H_IN_IDX))),
    .inc_i (h_in_data),
    .idx_o (in_idx)
  );

  mbox_index #(.IDX_W(IDX_W)) u_out_idx (
    .clk_i, .rst_ni,
    .clr_i (c_wr_out_idx | (host_wr & (host_addr_i == H_OUT_IDX))),
    .inc_i (h_out_data),
    .idx_o (out_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_mask_q  <= '0;
      out_mask_q <= '0;
    end else begin
      if (c_wr_in_mask)                             in_mask_q  <= pwdata_i;
      if (host_wr && host_addr_i == H_OUT_MASK)     out_mask_q <= host_data_i;
    end
  end

  logic [BYTE_W-1:0] in_h_rd, in_c_rd, out_h_rd, out_c_rd;

  mbox_buffer #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_in_buf (
    .clk_i,
    .h_we_i    (h_in_data & ~host_rw_ni),
    .h_addr_i  (in_idx),
    .h_wdata_i (host_data_i),
    .h_rdata_o (in_h_rd),
    .c_we_i    (apb_wr & in_buf_hit),
    .c_addr_i  (paddr_i[IDX_W-1:0]),
    .c_wdata_i (pwdata_i),
    .c_rdata_o (in_c_rd)
  );

  mbox_buffer #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_out_buf (
    .clk_i,
    .h_we_i    (h_out_data & ~host_rw_ni),
    .h_addr_i  (out_idx),
    .h_wdata_i (host_data_i),
    .h_rdata_o (out_h_rd),
    .c_we_i    (apb_wr & out_buf_hit),
    .c_addr_i  (paddr_i[IDX_W-1:0]),
    .c_wdata_i (pwdata_i),
    .c_rdata_o (out_c_rd)
  );

  // ---------------- read paths ----------------
  logic [BYTE_W-1:0] c_byte, h_byte;

  always_comb begin
    c_byte = '0;
    if (in_buf_hit)       c_byte = in_c_rd;
    else if (out_buf_hit) c_byte = out_c_rd;
    else if (reg_hit) begin
      case (reg_off)
        C_IN_FLAG:  c_byte = BYTE_W'(in_flag);
        C_OUT_FLAG: c_byte = BYTE_W'(out_flag);
        C_IN_MASK:  c_byte = in_mask_q;
        C_OUT_MASK: c_byte = out_mask_q;
        C_IN_IDX:   c_byte = BYTE_W'(in_idx);
        C_OUT_IDX:  c_byte = BYTE_W'(out_idx);
        default:    c_byte = '0;
      endcase
    end
  end
  assign prdata_o = PRDATA_W'(c_byte);

  always_comb begin
    case (host_addr_i)
      H_IN_FLAG:  h_byte = BYTE_W'(in_flag);
      H_OUT_FLAG: h_byte = BYTE_W'(out_flag);
      H_IN_IDX:   h_byte = BYTE_W'(in_idx);
      H_OUT_IDX:  h_byte = BYTE_W'(out_idx);
      H_IN_DATA:  h_byte = in_h_rd;
      H_OUT_DATA: h_byte = out_h_rd;
      H_OUT_MASK: h_byte = out_mask_q;
      default:    h_byte = in_mask_q;
    endcase
  end

  assign host_data_oe_o = ~host_cs_ni & host_rw_ni & ~host_oe_ni;
  assign host_data_o    = host_data_oe_o ? h_byte : '0;

  assign cpu_irq_o  = in_flag  & in_mask_q[0];
  assign host_irq_o = out_flag & out_mask_q[0];
endmodule

// File: tb/mbox_bridge_test.sv
module mbox_bridge_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [9:0] paddr = '0;
  logic [7:0] pwdata = '0;
  logic [15:0] prdata;
  logic cs_n = 1, as_n = 1, rw_n = 1, oe_n = 1;
  logic [2:0] haddr = '0;
  logic [7:0] hdin = '0, hdout;
  logic hoe, cpu_irq, host_irq;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .host_cs_ni(cs_n), .host_as_ni(as_n), .host_rw_ni(rw_n), .host_oe_ni(oe_n),
    .host_addr_i(haddr), .host_data_i(hdin), .host_data_o(hdout),
    .host_data_oe_o(hoe), .cpu_irq_o(cpu_irq), .host_irq_o(host_irq)
  );

  // reference model
  logic [7:0] m_in [256];
  logic [7:0] m_out [256];
  bit m_if, m_of;
  logic [7:0] m_ii, m_oi, m_im, m_om;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_host(input logic [2:0] a);
    case (a)
      3'd0: return {7'd0, m_if};
      3'd1: return {7'd0, m_of};
      3'd2: return m_ii;
      3'd3: return m_oi;
      3'd4: return m_in[m_ii];
      3'd5: return m_out[m_oi];
      3'd6: return m_om;
      default: return m_im;
    endcase
  endfunction

  function automatic logic [15:0] exp_apb(input logic [9:0] a);
    if (a < 10'h100) return {8'd0, m_in[a[7:0]]};
    if (a < 10'h200) return {8'd0, m_out[a[7:0]]};
    case (a)
      10'h200: return {15'd0, m_if};
      10'h201: return {15'd0, m_of};
      10'h202: return {8'd0, m_im};
      10'h203: return {8'd0, m_om};
      10'h204: return {8'd0, m_ii};
      10'h205: return {8'd0, m_oi};
      default: return 16'd0;
    endcase
  endfunction

  task automatic model_host_wr(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: if (d == 8'h01) m_if = 1; else if (d == 8'h00) m_if = 0;
      3'd1: m_of = 0;
      3'd2: m_ii = 0;
      3'd3: m_oi = 0;
      3'd4: begin m_in[m_ii] = d; m_ii++; end
      3'd5: begin m_out[m_oi] = d; m_oi++; end
      3'd6: m_om = d;
      default: ;
    endcase
  endtask

  task automatic model_apb_wr(input logic [9:0] a, input logic [7:0] d);
    if (a < 10'h100) m_in[a[7:0]] = d;
    else if (a < 10'h200) m_out[a[7:0]] = d;
    else case (a)
      10'h200: m_if = 0;
      10'h201: if (d == 8'h01) m_of = 1; else if (d == 8'h00) m_of = 0;
      10'h202: m_im = d;
      10'h204: if (d == 8'h00) m_ii = 0;
      10'h205: if (d == 8'h00) m_oi = 0;
      default: ;
    endcase
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; rw_n = 0; haddr = a; hdin = d; as_n = 0;
    @(negedge clk); as_n = 1;
    @(negedge clk); cs_n = 1; rw_n = 1;
    model_host_wr(a, d);
  endtask

  task automatic host_rd(input logic [2:0] a, input string req);
    logic [7:0] e;
    @(negedge clk); cs_n = 0; rw_n = 1; haddr = a; as_n = 0; oe_n = 0;
    @(negedge clk);
    e = exp_host(a);
    chk(hdout == e && hoe, req, {hoe, hdout}, {1'b1, e});
    as_n = 1;
    @(negedge clk); cs_n = 1; oe_n = 1;
    if (a == 3'd4) m_ii++;
    if (a == 3'd5) m_oi++;
  endtask

  task automatic apb_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    model_apb_wr(a, d);
  endtask

  task automatic apb_rd(input logic [9:0] a, input string req);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    #1 chk(prdata == exp_apb(a), req, prdata, exp_apb(a));
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic irq_chk(input string req);
    @(negedge clk);
    chk(cpu_irq == (m_if & m_im[0]), req, cpu_irq, m_if & m_im[0]);
    chk(host_irq == (m_of & m_om[0]), req, host_irq, m_of & m_om[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_if = 0; m_of = 0; m_ii = 0; m_oi = 0; m_im = 0; m_om = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk(!cpu_irq && !host_irq && !hoe && hdout == 0, "R1", {cpu_irq, host_irq, hoe}, 0);
    for (int a = 10'h200; a < 10'h206; a++) apb_rd(10'(a), "R1");

    // R6 fill both buffers directly, read some back
    for (int a = 0; a < 512; a++) apb_wr(10'(a), 8'($urandom));
    for (int a = 0; a < 512; a += 37) apb_rd(10'(a), "R6");
    apb_rd(10'h1FF, "R6");
    apb_rd(10'h3A5, "R6 unmapped");

    // R7 setup-only and unselected writes have no effect
    @(negedge clk); psel = 1; pwrite = 1; paddr = 10'h201; pwdata = 8'h01; penable = 0;
    @(negedge clk); psel = 0; penable = 1;
    @(negedge clk); penable = 0; pwrite = 0;
    apb_rd(10'h201, "R7");
    @(negedge clk); psel = 1; pwrite = 0; paddr = 10'h010; pwdata = 8'hEE; penable = 1;
    @(negedge clk); psel = 0; penable = 0;
    apb_rd(10'h010, "R7");

    // R2 inbound flag and R8 interrupt with mask
    host_wr(3'd0, 8'h01); irq_chk("R8 masked");
    apb_wr(10'h202, 8'h01); irq_chk("R8 unmasked");
    host_wr(3'd0, 8'h07); host_rd(3'd0, "R2 odd code");
    apb_wr(10'h200, 8'h5A); irq_chk("R2 peer clear");
    host_rd(3'd0, "R2"); host_rd(3'd7, "R8");

    // R3 outbound flag and R9
    apb_wr(10'h201, 8'h01); irq_chk("R9 masked");
    host_wr(3'd6, 8'h01); irq_chk("R9 unmasked");
    apb_wr(10'h201, 8'h80); apb_rd(10'h201, "R3 odd code");
    host_wr(3'd1, 8'hC3); irq_chk("R3 peer clear");
    apb_wr(10'h201, 8'h01); apb_wr(10'h201, 8'h00); irq_chk("R3 own clear");
    apb_rd(10'h203, "R9");

    // R5 wrap through 256 host writes plus more; other buffer untouched
    host_wr(3'd2, 8'hFF);
    for (int i = 0; i < 260; i++) host_wr(3'd4, 8'(i * 3 + 1));
    host_rd(3'd2, "R5 wrap");
    for (int a = 10'h100; a < 10'h200; a += 51) apb_rd(10'(a), "R5 isolation");
    apb_rd(10'h002, "R5 overwrite");
    host_wr(3'd3, 8'h00);
    for (int i = 0; i < 6; i++) host_rd(3'd5, "R5 read step");
    apb_rd(10'h205, "R5");

    // R4 index reset rules
    apb_wr(10'h205, 8'h03); host_rd(3'd3, "R4 nonzero ignored");
    apb_wr(10'h205, 8'h00); host_rd(3'd3, "R4 apb reset");
    host_wr(3'd4, 8'h11); host_wr(3'd2, 8'h99); apb_rd(10'h204, "R4 host clear");

    // R10 output enable gating
    @(negedge clk); cs_n = 0; rw_n = 1; oe_n = 1; haddr = 3'd6;
    #1 chk(!hoe && hdout == 0, "R10 oe high", {hoe, hdout}, 0);
    rw_n = 0; oe_n = 0;
    #1 chk(!hoe && hdout == 0, "R10 write", {hoe, hdout}, 0);
    cs_n = 1; rw_n = 1;
    #1 chk(!hoe && hdout == 0, "R10 cs high", {hoe, hdout}, 0);
    oe_n = 1;

    // R11 long strobe counts once; strobe with cs high ignored
    host_wr(3'd2, 8'h00);
    @(negedge clk); cs_n = 0; rw_n = 0; haddr = 3'd4; hdin = 8'h42; as_n = 0;
    repeat (5) @(negedge clk);
    as_n = 1; @(negedge clk); cs_n = 1; rw_n = 1;
    model_host_wr(3'd4, 8'h42);
    apb_rd(10'h204, "R11 once");
    @(negedge clk); haddr = 3'd4; rw_n = 0; as_n = 0;
    @(negedge clk); as_n = 1; @(negedge clk); rw_n = 1;
    apb_rd(10'h204, "R11 cs high");
    apb_rd(10'h000, "R11");

    // R12 collisions: flag clear vs set, index reset vs increment
    @(negedge clk); cs_n = 0; rw_n = 0; haddr = 3'd0; hdin = 8'h01; as_n = 0;
    psel = 1; pwrite = 1; paddr = 10'h200; pwdata = 8'h33;
    @(negedge clk); as_n = 1; penable = 1;
    @(negedge clk); cs_n = 1; rw_n = 1; psel = 0; penable = 0; pwrite = 0;
    m_if = 0;
    host_rd(3'd0, "R12 flag");
    host_wr(3'd4, 8'h21);
    @(negedge clk); cs_n = 0; rw_n = 1; haddr = 3'd4; as_n = 0;
    psel = 1; pwrite = 1; paddr = 10'h204; pwdata = 8'h00;
    @(negedge clk); as_n = 1; penable = 1;
    @(negedge clk); cs_n = 1; psel = 0; penable = 0; pwrite = 0;
    m_ii = 0;
    apb_rd(10'h204, "R12 index");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned op = $urandom_range(0, 4);
      logic [7:0] d = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'($urandom_range(0, 1));
      case (op)
        0: host_wr(3'($urandom), d);
        1: host_rd(3'($urandom), "R5 random host read");
        2: apb_wr(($urandom_range(0, 1) == 0) ? 10'($urandom_range(0, 511))
                                               : 10'(10'h200 + $urandom_range(0, 7)), d);
        3: apb_rd(($urandom_range(0, 1) == 0) ? 10'($urandom_range(0, 511))
                                               : 10'(10'h200 + $urandom_range(0, 7)), "R6 random apb read");
        default: irq_chk("R8 R9 random");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule